// File: doc/BRIEF.md
# Shared Word Store with APB and DMA Arbitration

A small word store is reached from two sides: an APB subordinate port used by software and a DMA-style request/grant port used by a data mover. A round-robin arbiter grants the store to at most one side per cycle. Each granted access keeps the store occupied for `HOLD_CYCLES` cycles, which models a slow macro. The arbiter does not grant again while the store is occupied.

The APB side raises its arbitration request from the setup phase onward. It keeps PREADY low during the access phase until its own grant has come and the access has finished. The number of wait states therefore follows the real grant and changes with DMA traffic; no fixed wait counter exists. The round-robin order bounds the worst case at `max(HOLD_CYCLES, 2*HOLD_CYCLES-2)` wait states, which is 2 for the default.

The DMA port is a valid/ready stream. `dma_req` is the valid and `dma_gnt` is the ready. A requester holds `dma_req`, `dma_we`, `dma_addr` and `dma_wdata` stable until it sees `dma_gnt` high in a cycle, and the transfer happens in that cycle. `dma_rvalid` pulses one cycle later for every granted access and carries read data on `dma_rdata`. The response side has no back-pressure. `DEPTH` must be a power of two.

Top module: `shared_store_arb`

## Requirements
- R1: While `psel` is low, `pready` is high. After reset, `pready` is high, and `dma_gnt` and `dma_rvalid` are low.
- R2: At most one side is granted in a cycle. After any grant, no further grant is given for `HOLD_CYCLES`-1 cycles.
- R3: An APB transfer completes (`psel`, `penable` and `pready` all high) only in the cycle directly after its grant. In a read, `prdata` in that cycle holds the addressed word.
- R4: `dma_rvalid` is high exactly in the cycle after each `dma_gnt`. For a read, `dma_rdata` then holds the addressed word.
- R5: When both sides request in a cycle where the store is free, the side that did not win the last grant wins. After reset, the APB side is treated as the next winner.
- R6: No APB transfer sees more than `max(HOLD_CYCLES, 2*HOLD_CYCLES-2)` wait states, for any DMA request pattern.
- R7: An APB transfer whose setup cycle finds the store free and no DMA request completes with zero wait states.
- R8: A word written by either port is returned by a later read from either port. Words reset to zero.
- R9: `dma_gnt` is high only while `dma_req` is high, and the APB side is granted only while `psel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB word address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, valid in the completion cycle |
| pready | output | 1 | APB ready; low while waiting for grant and access |
| dma_req | input | 1 | DMA request (stream valid) |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | ADDR_W | DMA word address |
| dma_wdata | input | DATA_W | DMA write data |
| dma_gnt | output | 1 | DMA grant (stream ready), same cycle as the request it accepts |
| dma_rvalid | output | 1 | DMA response, one cycle after the grant |
| dma_rdata | output | DATA_W | DMA read data, valid with `dma_rvalid` |

## Verification
A DMA grant is due in the cycle of a request that wins. Its response comes one cycle later, and APB completion comes one cycle after the APB grant. The expected APB wait count is therefore 0, 1 or 2 in the directed cases. Each case is set by when the previous DMA grant happened and which side won last.

The bench drives inputs 1 ns after a rising edge and reads every output at the falling edge, so each reading falls in the cycle the requirement names. A scoreboard queues the expected words per port when a transfer is issued. A monitor compares them on the exact completion or `dma_rvalid` cycle. Random DMA traffic at three densities checks the wait bound on every APB transfer.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  typedef enum logic {
    WIN_APB = 1'b0,
    WIN_DMA = 1'b1
  } winner_e;

  // Worst-case APB wait states for a given store occupancy.
  function automatic int apb_wait_bound(int hold);
    int twice;
    twice = 2 * hold - 2;
    return (twice > hold) ? twice : hold;
  endfunction

endpackage

// File: rtl/ssa_rr_arbiter.sv
module ssa_rr_arbiter
  import ssa_pkg::*;
#(
  parameter int HOLD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_apb,
  input  logic req_dma,
  output logic gnt_apb,
  output logic gnt_dma
);

  localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) + 1 : 1;

  logic    store_free;
  logic    any_gnt;
  winner_e last_q;

  assign any_gnt = gnt_apb | gnt_dma;

  generate
    if (HOLD_CYCLES > 1) begin : g_occupy
      logic [CW-1:0] busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busy_q <= '0;
        end else if (any_gnt) begin
          busy_q <= CW'(HOLD_CYCLES - 1);
        end else if (busy_q != '0) begin
          busy_q <= busy_q - 1'b1;
        end
      end
      assign store_free = (busy_q == '0);
    end else begin : g_single
      assign store_free = 1'b1;
    end
  endgenerate

  // Round-robin between two sides: a tie goes to the last loser.
  always_comb begin
    gnt_apb = store_free && req_apb && (!req_dma || last_q == WIN_DMA);
    gnt_dma = store_free && req_dma && !(req_apb && last_q == WIN_DMA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= WIN_DMA;
    end else if (gnt_apb) begin
      last_q <= WIN_APB;
    end else if (gnt_dma) begin
      last_q <= WIN_DMA;
    end
  end

endmodule

// File: rtl/ssa_apb_front.sv
module ssa_apb_front (
  input  logic clk,
  input  logic rst_n,
  input  logic psel,
  input  logic penable,
  input  logic gnt,
  output logic req,
  output logic pready
);

  logic served_q;
  logic in_access;
  logic finish;

  assign in_access = psel && penable;
  assign finish    = in_access && served_q;

  // Request stays up from setup until the store is granted.
  assign req    = psel && !served_q;
  assign pready = !in_access || served_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      served_q <= 1'b0;
    end else if (!psel || finish) begin
      served_q <= 1'b0;
    end else if (gnt) begin
      served_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ssa_storage.sv
module ssa_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              sel_dma,
  input  logic              apb_we,
  input  logic [ADDR_W-1:0] apb_addr,
  input  logic [DATA_W-1:0] apb_wdata,
  input  logic              dma_we,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              we_m;
  logic [ADDR_W-1:0] addr_m;
  logic [DATA_W-1:0] wdata_m;

  always_comb begin
    if (sel_dma) begin
      we_m    = dma_we;
      addr_m  = dma_addr;
      wdata_m = dma_wdata;
    end else begin
      we_m    = apb_we;
      addr_m  = apb_addr;
      wdata_m = apb_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '0;
      end
      rd_q <= '0;
    end else if (acc_en) begin
      rd_q <= mem_q[addr_m];
      if (we_m) begin
        mem_q[addr_m] <= wdata_m;
      end
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/shared_store_arb.sv
module shared_store_arb #(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 16,
  parameter int HOLD_CYCLES = 2,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_gnt,
  output logic              dma_rvalid,
  output logic [DATA_W-1:0] dma_rdata
);

  logic              apb_req;
  logic              apb_gnt;
  logic              dma_rvalid_q;
  logic [DATA_W-1:0] store_rd;

  ssa_apb_front u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .gnt     (apb_gnt),
    .req     (apb_req),
    .pready  (pready)
  );

  ssa_rr_arbiter #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_apb (apb_req),
    .req_dma (dma_req),
    .gnt_apb (apb_gnt),
    .gnt_dma (dma_gnt)
  );

  ssa_storage #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (apb_gnt | dma_gnt),
    .sel_dma   (dma_gnt),
    .apb_we    (pwrite),
    .apb_addr  (paddr),
    .apb_wdata (pwdata),
    .dma_we    (dma_we),
    .dma_addr  (dma_addr),
    .dma_wdata (dma_wdata),
    .rdata     (store_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_rvalid_q <= 1'b0;
    end else begin
      dma_rvalid_q <= dma_gnt;
    end
  end

  assign dma_rvalid = dma_rvalid_q;
  assign prdata     = store_rd;
  assign dma_rdata  = store_rd;

endmodule

// File: rtl/shared_store_arb_chk.sv
module shared_store_arb_chk
  import ssa_pkg::*;
#(
  parameter int HOLD_CYCLES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic psel,
  input logic penable,
  input logic pready,
  input logic dma_req,
  input logic dma_gnt,
  input logic dma_rvalid,
  input logic apb_req,
  input logic apb_gnt
);

  localparam int WAIT_MAX = apb_wait_bound(HOLD_CYCLES);

  int   wait_cnt;
  int   since_gnt;
  logic apb_lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt   <= 0;
      since_gnt  <= HOLD_CYCLES;
      apb_lost_q <= 1'b0;
    end else begin
      if (psel && penable && !pready) wait_cnt <= wait_cnt + 1;
      else if (!(psel && penable) || pready) wait_cnt <= 0;
      if (apb_gnt || dma_gnt) since_gnt <= 0;
      else if (since_gnt < HOLD_CYCLES) since_gnt <= since_gnt + 1;
      if (apb_gnt) apb_lost_q <= 1'b0;
      else if (dma_gnt && apb_req) apb_lost_q <= 1'b1;
    end
  end

  assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !psel |-> pready);

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(apb_gnt && dma_gnt));

  assert_grant_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (apb_gnt || dma_gnt) |-> (since_gnt >= HOLD_CYCLES - 1));

  assert_done_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready) |-> $past(apb_gnt));

  assert_dma_response_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_gnt |=> dma_rvalid);

  assert_dma_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rvalid |-> $past(dma_gnt));

  assert_apb_wins_after_dma_R5: assert property (@(posedge clk) disable iff (!rst_n)
    apb_lost_q |-> !dma_gnt);

  assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= WAIT_MAX);

  assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt |-> dma_req) and (apb_gnt |-> psel));

endmodule

bind shared_store_arb shared_store_arb_chk #(
  .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .psel       (psel),
  .penable    (penable),
  .pready     (pready),
  .dma_req    (dma_req),
  .dma_gnt    (dma_gnt),
  .dma_rvalid (dma_rvalid),
  .apb_req    (apb_req),
  .apb_gnt    (apb_gnt)
);

// File: tb/shared_store_arb_tb_top.sv
`timescale 1ns/1ps
module shared_store_arb_tb_top;
  import ssa_pkg::*;

  localparam int DW    = 32;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int HOLD  = 2;
  localparam int WB    = 2; // max(HOLD, 2*HOLD-2) for HOLD = 2

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic          pready;
  logic          dma_req = 1'b0, dma_we = 1'b0;
  logic [AW-1:0] dma_addr = '0;
  logic [DW-1:0] dma_wdata = '0;
  logic          dma_gnt, dma_rvalid;
  logic [DW-1:0] dma_rdata;

  shared_store_arb #(.DATA_W(DW), .DEPTH(DEPTH), .HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_gnt(dma_gnt), .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] apb_exp_q [$];
  logic [DW:0]   dma_exp_q [$]; // top bit: read expected

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares results in the cycle they are due.
  always @(negedge clk) begin
    if (rst_n) begin
      if (psel && penable && pready && !pwrite) begin
        if (apb_exp_q.size() == 0) check(0, "R3 unexpected apb read", prdata, 0);
        else begin
          logic [DW-1:0] e;
          e = apb_exp_q.pop_front();
          check(prdata == e, "R3/R8 apb read data", prdata, e);
        end
      end
      if (dma_rvalid) begin
        if (dma_exp_q.size() == 0) check(0, "R4 unexpected dma response", 1, 0);
        else begin
          logic [DW:0] d;
          d = dma_exp_q.pop_front();
          if (d[DW]) check(dma_rdata == d[DW-1:0], "R4/R8 dma read data", dma_rdata, d[DW-1:0]);
        end
      end
    end
  end

  task automatic apb_xfer(bit we, logic [AW-1:0] a, logic [DW-1:0] d, output int waits);
    if (we) model[a] = d;
    else apb_exp_q.push_back(model[a]);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = we; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    waits = 0;
    forever begin
      @(negedge clk);
      if (pready) break;
      waits++;
    end
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic dma_xfer(bit we, logic [AW-1:0] a, logic [DW-1:0] d, output int waits);
    if (we) model[a] = d;
    dma_exp_q.push_back({!we, model[a]});
    @(posedge clk); #1;
    dma_req = 1'b1; dma_we = we; dma_addr = a; dma_wdata = d;
    waits = 0;
    forever begin
      @(negedge clk);
      if (dma_gnt) break;
      waits++;
    end
    @(posedge clk); #1;
    dma_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int aw, dw;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(pready == 1'b1, "R1 reset pready", pready, 1);
    check(dma_gnt == 1'b0, "R1 reset dma_gnt", dma_gnt, 0);
    check(dma_rvalid == 1'b0, "R1 reset dma_rvalid", dma_rvalid, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R5: first tie after reset goes to APB; R8 reset contents read as zero.
    fork
      apb_xfer(1'b0, 4'd2, '0, aw);
      dma_xfer(1'b0, 4'd9, '0, dw);
    join
    check(aw == 0, "R5 apb wins first tie (waits)", aw, 0);
    check(dw == 2, "R5 dma waits after losing tie", dw, 2);
    repeat (2) @(posedge clk);

    // R7: lone APB transfers, zero waits.
    apb_xfer(1'b1, 4'd1, 32'hA5A5_0001, aw);
    check(aw == 0, "R7 lone apb write waits", aw, 0);
    apb_xfer(1'b0, 4'd1, '0, aw);
    check(aw == 0, "R7 lone apb read waits", aw, 0);
    repeat (2) @(posedge clk);

    // R6 worst case: last winner APB, DMA and APB tie, DMA wins, APB waits 2.
    fork
      apb_xfer(1'b0, 4'd1, '0, aw);
      dma_xfer(1'b1, 4'd10, 32'hD0D0_000A, dw);
    join
    check(aw == WB, "R6/R5 worst-case apb waits", aw, WB);
    check(dw == 0, "R5 dma wins tie after apb", dw, 0);
    repeat (2) @(posedge clk);

    // R2: DMA granted the cycle before APB setup; store busy gives one wait.
    fork
      dma_xfer(1'b0, 4'd10, '0, dw);
      begin @(posedge clk); apb_xfer(1'b1, 4'd3, 32'h0000_0033, aw); end
    join
    check(aw == 1, "R2 apb one wait behind busy store", aw, 1);
    repeat (2) @(posedge clk);

    // R1: pready stays high with psel low during DMA activity.
    fork
      dma_xfer(1'b1, 4'd11, 32'h1111_000B, dw);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check(pready == 1'b1, "R1 pready idle during dma", pready, 1);
      end
    join
    repeat (2) @(posedge clk);

    // R8: cross-port integrity.
    dma_xfer(1'b1, 4'd4, 32'hCAFE_0004, dw);
    apb_xfer(1'b0, 4'd4, '0, aw);
    apb_xfer(1'b1, 4'd12, 32'hBEEF_000C, aw);
    dma_xfer(1'b0, 4'd12, '0, dw);
    repeat (2) @(posedge clk);

    // R6: random DMA traffic at three densities, wait bound on every APB transfer.
    for (int round = 0; round < 3; round++) begin
      int gap_max;
      gap_max = (round == 0) ? 0 : (round == 1) ? 3 : 10;
      fork
        for (int n = 0; n < 120; n++) begin
          int g, w;
          g = (gap_max == 0) ? 0 : $urandom_range(gap_max);
          repeat (g) @(posedge clk);
          dma_xfer(1'($urandom_range(1)), AW'(8 + $urandom_range(7)), $urandom, w);
        end
        for (int n = 0; n < 50; n++) begin
          int w;
          apb_xfer(1'($urandom_range(1)), AW'($urandom_range(7)), $urandom, w);
          check(w <= WB, "R6 apb wait bound under traffic", w, WB);
        end
      join
    end

    repeat (4) @(posedge clk);
    check(apb_exp_q.size() == 0, "R3 all apb reads returned", apb_exp_q.size(), 0);
    check(dma_exp_q.size() == 0, "R4 all dma responses returned", dma_exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule